// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block keeps the contents of an asynchronous page-mode DRAM module alive. A free-running interval timer produces one refresh credit per interval. Credits are stored in a small saturating counter. While any credit is outstanding, the block asks the memory access controller for the strobes over a level request/grant handshake. Once granted, it runs CAS-before-RAS refresh cycles. In these cycles the DRAM takes the row from its own internal counter, so the block drives no address. Every fitted bank's RAS line is asserted together, and each cycle is bracketed by precharge time. Outstanding credits let the access controller keep a page open across a few intervals. When the counter is full, an urgent flag tells the controller to close the page and grant.

A level sleep request moves the module into self refresh. The block starts a CAS-before-RAS cycle and keeps RAS low for the self-refresh entry time before it raises the sleep acknowledge. When the request is withdrawn, RAS is driven high for the exit recovery time. The acknowledge falls only after that recovery has elapsed. Refresh before entry is distributed, so no burst follows the exit. The stored credits are discarded and the interval timer restarts, so the next refresh falls one full interval after the wake-up. All timing values are given in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, and directly after it, every RAS and CAS output is high (inactive) and `arb_req`, `ref_urgent` and `sleep_ack` are low.
- R2: The interval timer adds one refresh credit every INTERVAL clock cycles. Starting from reset with no grant, `arb_req` is first seen high INTERVAL rising edges after reset is released.
- R3: Credits saturate at PEND_MAX. If the grant is withheld for k intervals, exactly min(k, PEND_MAX) refresh cycles are run back to back once the grant arrives, and after that `arb_req` falls.
- R4: `ref_urgent` is high exactly while the credit count equals PEND_MAX, and `arb_req` is always high while `ref_urgent` is high.
- R5: If a credit arrives in the same cycle that a refresh completes, both are applied, even when the counter is full. With PEND_MAX credits stored, a completion that lines up with a tick leads to PEND_MAX+1 refresh cycles in total.
- R6: In every refresh cycle CAS falls exactly T_CSR cycles before RAS. In a normal refresh, RAS stays low for exactly T_RAS cycles.
- R7: RAS and CAS are both high for at least T_RP cycles before each CAS fall, and for at least T_RP cycles before `arb_req` is released.
- R8: All `dram_ras_n` bits carry the same value in every cycle, and so do all `dram_cas_n` bits.
- R9: A strobe is driven low only while `arb_gnt` is high. Once strobes are active, `arb_req` stays high until the sequence has returned to idle.
- R10: Self-refresh entry starts with CAS low, then RAS low. `sleep_ack` rises once RAS has been low for exactly T_RASS cycles, and RAS and CAS are both low at that point.
- R11: While `sleep_ack` and `sleep_req` are both high, the strobes do not change, whatever the interval timer would do.
- R12: After `sleep_req` falls, RAS and CAS are high for exactly T_RPS cycles with `sleep_ack` still high, and then `sleep_ack` falls.
- R13: After self-refresh exit no burst is run. `arb_req` is low when `sleep_ack` falls and rises again exactly INTERVAL cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arb_gnt | input | 1 | Grant from the access controller (level, held while `arb_req` is high) |
| sleep_req | input | 1 | Level request to enter self refresh, low to leave it |
| arb_req | output | 1 | Request for the DRAM strobes |
| ref_urgent | output | 1 | Credit counter full; the controller should close its page |
| sleep_ack | output | 1 | High from self-refresh entry until exit recovery is complete |
| dram_ras_n | output | NUM_BANKS | Row strobes, active low, one per bank |
| dram_cas_n | output | CAS_LANES | Column strobes, active low, one per byte lane |

## Verification
The two functions that can fall in the same cycle are the interval tick and the completion of a refresh. With the counter already full, one would add a credit while the other removes one. The bench records the edge at which the first credit appeared. It then withholds the grant for PEND_MAX intervals and grants on a cycle computed from the strobe phase lengths, so that the first completion lands exactly on the next tick. It judges the result by counting RAS falls until the request drops, expecting PEND_MAX+1. A design that drops the tick because the counter looked full, or that applies only one of the two updates, yields a different count.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // strobes high, waiting for work and grant
    ST_PRE,    // precharge before the refresh cycle
    ST_CSR,    // CAS low, RAS still high
    ST_RAS,    // both low, normal refresh
    ST_POST,   // precharge before giving the strobes back
    ST_SRE,    // both low, counting self-refresh entry time
    ST_SELF,   // parked in self refresh
    ST_SRX     // RAS high, exit recovery
  } seq_state_t;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dref_interval_timer.sv
module dref_interval_timer #(
  parameter int unsigned INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic tick_o
);
  localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold_i || cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  assign tick_o = !hold_i && (cnt_q == LAST);
endmodule

// File: rtl/dref_pending_ctr.sv
module dref_pending_ctr #(
  parameter int unsigned PEND_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic done_i,
  input  logic clear_i,
  output logic pending_o,
  output logic urgent_o
);
  localparam int unsigned CW = $clog2(PEND_MAX + 1);
  localparam logic [CW-1:0] LIM = CW'(PEND_MAX);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] after_dec;

  // completion is applied first, so a tick in the same cycle still finds room
  always_comb begin
    after_dec = cnt_q;
    if (done_i && cnt_q != '0) after_dec = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (tick_i && after_dec < LIM) begin
      cnt_q <= after_dec + CW'(1);
    end else begin
      cnt_q <= after_dec;
    end
  end

  assign pending_o = (cnt_q != '0);
  assign urgent_o  = (cnt_q >= LIM);
endmodule

// File: rtl/dref_strobe_fsm.sv
module dref_strobe_fsm
  import dref_pkg::*;
#(
  parameter int unsigned T_RP   = 4,
  parameter int unsigned T_CSR  = 1,
  parameter int unsigned T_RAS  = 5,
  parameter int unsigned T_RASS = 10000,
  parameter int unsigned T_RPS  = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic need_ref_i,
  input  logic sleep_req_i,
  input  logic gnt_i,
  output logic req_o,
  output logic ras_act_o,
  output logic cas_act_o,
  output logic sleep_ack_o,
  output logic ref_done_o,
  output logic asleep_o
);
  localparam int unsigned MAXT =
    max_of(max_of(max_of(T_RP, T_CSR), max_of(T_RAS, T_RASS)), T_RPS);
  localparam int unsigned DW = (MAXT > 1) ? $clog2(MAXT) : 1;

  seq_state_t state_q, state_d;
  logic [DW-1:0] dly_q, dly_d;
  logic sleep_mode_q, sleep_mode_d;
  logic dly_zero;

  assign dly_zero = (dly_q == '0);

  always_comb begin
    state_d      = state_q;
    dly_d        = dly_zero ? '0 : dly_q - DW'(1);
    sleep_mode_d = sleep_mode_q;
    ref_done_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (gnt_i && (sleep_req_i || need_ref_i)) begin
          state_d      = ST_PRE;
          dly_d        = DW'(T_RP - 1);
          sleep_mode_d = sleep_req_i;
        end
      end
      ST_PRE: if (dly_zero) begin
        state_d = ST_CSR;
        dly_d   = DW'(T_CSR - 1);
      end
      ST_CSR: if (dly_zero) begin
        if (sleep_mode_q) begin
          state_d = ST_SRE;
          dly_d   = DW'(T_RASS - 1);
        end else begin
          state_d = ST_RAS;
          dly_d   = DW'(T_RAS - 1);
        end
      end
      ST_RAS: if (dly_zero) begin
        state_d = ST_POST;
        dly_d   = DW'(T_RP - 1);
      end
      ST_POST: if (dly_zero) begin
        state_d    = ST_IDLE;
        ref_done_o = 1'b1;
      end
      ST_SRE: if (dly_zero) state_d = ST_SELF;
      ST_SELF: if (!sleep_req_i) begin
        state_d = ST_SRX;
        dly_d   = DW'(T_RPS - 1);
      end
      ST_SRX: if (dly_zero) begin
        state_d      = ST_IDLE;
        sleep_mode_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      dly_q        <= '0;
      sleep_mode_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      dly_q        <= dly_d;
      sleep_mode_q <= sleep_mode_d;
    end
  end

  assign req_o       = (state_q != ST_IDLE) || sleep_req_i || need_ref_i;
  assign ras_act_o   = (state_q == ST_RAS) || (state_q == ST_SRE) || (state_q == ST_SELF);
  assign cas_act_o   = ras_act_o || (state_q == ST_CSR);
  assign sleep_ack_o = (state_q == ST_SELF) || (state_q == ST_SRX);
  assign asleep_o    = sleep_ack_o || (state_q == ST_SRE);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned CAS_LANES = 4,
  parameter int unsigned INTERVAL  = 1560,
  parameter int unsigned PEND_MAX  = 8,
  parameter int unsigned T_RP      = 4,
  parameter int unsigned T_CSR     = 1,
  parameter int unsigned T_RAS     = 5,
  parameter int unsigned T_RASS    = 10000,
  parameter int unsigned T_RPS     = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arb_gnt,
  input  logic                 sleep_req,
  output logic                 arb_req,
  output logic                 ref_urgent,
  output logic                 sleep_ack,
  output logic [NUM_BANKS-1:0] dram_ras_n,
  output logic [CAS_LANES-1:0] dram_cas_n
);
  logic tick, ref_done, asleep, pending, ras_act, cas_act;

  dref_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (asleep),
    .tick_o (tick)
  );

  dref_pending_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .done_i    (ref_done),
    .clear_i   (asleep),
    .pending_o (pending),
    .urgent_o  (ref_urgent)
  );

  dref_strobe_fsm #(
    .T_RP(T_RP), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RASS(T_RASS), .T_RPS(T_RPS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .need_ref_i  (pending),
    .sleep_req_i (sleep_req),
    .gnt_i       (arb_gnt),
    .req_o       (arb_req),
    .ras_act_o   (ras_act),
    .cas_act_o   (cas_act),
    .sleep_ack_o (sleep_ack),
    .ref_done_o  (ref_done),
    .asleep_o    (asleep)
  );

  // every bank and lane sees the same strobe during refresh
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ras
    assign dram_ras_n[b] = !ras_act;
  end
  for (genvar l = 0; l < CAS_LANES; l++) begin : g_cas
    assign dram_cas_n[l] = !cas_act;
  end
endmodule

// File: rtl/dref_seq_checker.sv
module dref_seq_checker #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned CAS_LANES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 arb_gnt,
  input logic                 sleep_req,
  input logic                 arb_req,
  input logic                 ref_urgent,
  input logic                 sleep_ack,
  input logic [NUM_BANKS-1:0] dram_ras_n,
  input logic [CAS_LANES-1:0] dram_cas_n
);
  AST_STROBE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n != '1 || dram_cas_n != '1) |-> arb_gnt); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n != '1 || dram_cas_n != '1) |=> arb_req); // R9
  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n[0]) |-> (dram_cas_n == '0) && $past(dram_cas_n == '0)); // R6
  AST_URGENT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> arb_req); // R4
  AST_ENTRY_RAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ack) |-> (dram_ras_n == '0) && (dram_cas_n == '0)); // R10
  AST_SELF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_ack && $past(sleep_ack) && $past(sleep_req)) |-> $stable(dram_ras_n) && $stable(dram_cas_n)); // R11
  AST_EXIT_RAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_ack) |-> (dram_ras_n == '1) && $past(dram_ras_n == '1)); // R12
endmodule

bind dram_refresh_seq dref_seq_checker #(.NUM_BANKS(NUM_BANKS), .CAS_LANES(CAS_LANES)) i_chk (.*);

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/100ps
module test_dram_refresh_seq;
  localparam int NB = 2, NL = 4, IVL = 40, PMAX = 3;
  localparam int TRP = 2, TCSR = 2, TRAS = 3, TRASS = 5, TRPS = 4;
  localparam int LAT = 1 + 2*TRP + TCSR + TRAS; // grant sample to completion edge

  logic clk = 1'b0, rst_n = 1'b0, arb_gnt = 1'b0, sleep_req = 1'b0;
  logic arb_req, ref_urgent, sleep_ack;
  logic [NB-1:0] dram_ras_n;
  logic [NL-1:0] dram_cas_n;

  int checks = 0, errors = 0, cyc = 0;
  bit gnt_en = 1'b0;
  int high_run = 0, ras_low_run = 0, cas_low_run = 0, ras_falls = 0, ras_rises = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_ack = 1'b0, p_req = 1'b0;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .NUM_BANKS(NB), .CAS_LANES(NL), .INTERVAL(IVL), .PEND_MAX(PMAX),
    .T_RP(TRP), .T_CSR(TCSR), .T_RAS(TRAS), .T_RASS(TRASS), .T_RPS(TRPS)
  ) i_dram_refresh_seq (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: samples at negedge+0.5, drives grant at negedge+1.5
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      if (!rst_n) begin
        cyc = 0;
      end else begin
        cyc++;
        chk(dram_ras_n == '0 || dram_ras_n == '1, "R8 ras", int'(dram_ras_n), 0);
        chk(dram_cas_n == '0 || dram_cas_n == '1, "R8 cas", int'(dram_cas_n), 0);
        if (dram_ras_n != '1 || dram_cas_n != '1) chk(arb_gnt, "R9 grant", arb_gnt, 1);
        if (p_cas && !dram_cas_n[0]) chk(high_run >= TRP, "R7 precharge", high_run, TRP);
        if (p_ras && !dram_ras_n[0]) begin
          ras_falls++;
          chk(cas_low_run == TCSR, "R6 cas lead", cas_low_run, TCSR);
        end
        if (!p_ras && dram_ras_n[0]) begin
          ras_rises++;
          if (!sleep_ack) chk(ras_low_run == TRAS, "R6 ras width", ras_low_run, TRAS);
        end
        if (!p_ack && sleep_ack) chk(ras_low_run == TRASS, "R10 entry", ras_low_run, TRASS);
        if (p_ack && !sleep_ack) chk(high_run == TRPS, "R12 exit", high_run, TRPS);
        if (p_req && !arb_req) chk(high_run >= TRP, "R7 release", high_run, TRP);
        high_run    = (dram_ras_n[0] && dram_cas_n[0]) ? high_run + 1 : 0;
        ras_low_run = !dram_ras_n[0] ? ras_low_run + 1 : 0;
        cas_low_run = !dram_cas_n[0] ? cas_low_run + 1 : 0;
      end
      p_ras = dram_ras_n[0]; p_cas = dram_cas_n[0]; p_ack = sleep_ack; p_req = arb_req;
      #1;
      arb_gnt = gnt_en && arb_req;
    end
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_req(input logic v);
    while (arb_req !== v) step();
  endtask

  initial begin
    int e, c0, x;
    repeat (3) step();
    // R1: outputs during reset
    chk(dram_ras_n == '1 && dram_cas_n == '1, "R1 strobes", int'(dram_ras_n), 3);
    chk(!arb_req && !ref_urgent && !sleep_ack, "R1 flags", int'({arb_req, ref_urgent, sleep_ack}), 0);
    rst_n = 1'b1;
    step();
    chk(!arb_req && dram_ras_n == '1, "R1 after release", int'(arb_req), 0);
    // R2: first credit INTERVAL edges after release
    wait_req(1'b1);
    chk(cyc == IVL, "R2 first request", cyc, IVL);
    chk(!ref_urgent, "R4 one credit", ref_urgent, 0);
    // R3/R4 sweep over grant hold-off lengths
    for (int k = 1; k <= PMAX + 2; k++) begin
      wait_req(1'b1);
      e = cyc;
      while (cyc < e + (k - 1) * IVL) step();
      chk(ref_urgent == (k >= PMAX), "R4 urgent at grant", ref_urgent, int'(k >= PMAX));
      c0 = ras_falls;
      gnt_en = 1'b1;
      step();
      wait_req(1'b0);
      gnt_en = 1'b0;
      chk(ras_falls - c0 == ((k < PMAX) ? k : PMAX), "R3 refresh count", ras_falls - c0,
          (k < PMAX) ? k : PMAX);
      chk(!ref_urgent, "R4 urgent cleared", ref_urgent, 0);
    end
    // R5: completion coinciding with a tick at saturation
    wait_req(1'b1);
    e = cyc;
    while (cyc < e + PMAX * IVL - LAT) step();
    chk(ref_urgent, "R5 saturated before grant", ref_urgent, 1);
    c0 = ras_falls;
    gnt_en = 1'b1;
    step();
    wait_req(1'b0);
    chk(ras_falls - c0 == PMAX + 1, "R5 tick with completion", ras_falls - c0, PMAX + 1);
    // R10/R11 self refresh entry and hold
    sleep_req = 1'b1;
    while (!sleep_ack) step();
    c0 = ras_falls + ras_rises;
    repeat (3 * IVL) step();
    chk(sleep_ack && dram_ras_n == '0 && dram_cas_n == '0, "R11 held", int'(dram_ras_n), 0);
    chk(ras_falls + ras_rises == c0, "R11 no strobe edges", ras_falls + ras_rises, c0);
    // R12/R13 exit and restart
    sleep_req = 1'b0;
    while (sleep_ack) step();
    x = cyc;
    chk(!arb_req, "R13 no burst after exit", arb_req, 0);
    chk(dram_ras_n == '1, "R12 ras high after exit", int'(dram_ras_n), 3);
    wait_req(1'b1);
    chk(cyc - x == IVL, "R13 next request", cyc - x, IVL);
    step();
    wait_req(1'b0);
    gnt_en = 1'b0;
    repeat (4) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule